// File: doc/BRIEF.md
# ATA Task-File Register Block

This block holds the host-visible register file of a single ATA channel that serves two drive slots. The host reaches it with byte-wide reads and writes. One select line picks between the eight-byte command block and the two-byte control block, and a three-bit offset picks the register. Each slot reports whether a device is fitted and of what kind: none, a fixed disk, or a packet device. The block keeps a separate copy of the address registers for each slot. It stores the drive/head and device-control bytes, and it produces status and error bytes for the host.

A write to the command register is decoded here at once. Identify, packet-start, abort and the no-data housekeeping commands get their status and error outcome in this block. Commands that move data are handed to a separate transfer engine through a one-cycle strobe that carries the command code and the slot. The block raises the channel interrupt line and clears it again.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, error reads 0x01, status 0x00, both slots' sector count and sector number 0x01, both cylinder bytes 0x00, drive/head 0x00, interrupt and transfer strobe low. The device-control byte resets to 0x08 (bit 2 soft reset, bit 1 interrupt disable, both 0).
- R2: Writes to command offsets 2 (sector count), 3 (sector number), 4 (cylinder low) and 5 (cylinder high) update the copies in both slots. Reads return the copy of the slot chosen by drive/head bit 4.
- R3: A drive/head write (offset 6) is stored with bits 7 and 5 set. If the newly chosen slot is empty, the write also sets error bit 2 and status bit 0.
- R4: Control offset 1 always reads 0xFF. When the chosen slot is empty (kind code 0 or 3), drive/head reads 0xA0 and every other offset, including alternate status at control offset 0, reads 0x00. Data offset 0 always reads 0x00.
- R5: A 0-to-1 change of control bit 2 sets status to 0x90 and error to 0x01, drops any pending interrupt, and stores the written control byte with bit 1 cleared.
- R6: A 1-to-0 change of control bit 2 clears status bit 7 and sets status bit 6. It clears drive/head bits 3..0 and sets sector count and sector number in both slots to 0x01. The cylinder pair becomes 0xEB14 for a packet-device slot (kind 2) and 0x0000 otherwise.
- R7: An aborted command sets status 0x41 and error 0x04 and raises the interrupt.
- R8: Command 0xEC to a disk (kind 1) or 0xA1 to a packet device (kind 2) sets error 0x00 and status 0x58, raises the interrupt, and pulses the transfer strobe with the code and slot. Either command sent to any other kind aborts.
- R9: Commands 0xEF, 0x91 and 0x10 complete at once. Status bits 7 and 0 are cleared and bits 6 and 4 are set, the error byte is unchanged, and the interrupt is raised.
- R10: Command 0xA0 to a packet device sets only that slot's sector count to 1. It clears status bits 7, 5 and 0, sets bit 3, pulses the transfer strobe, and raises no interrupt. Sent to any other kind, it aborts.
- R11: A raised interrupt becomes pending only while control bit 1 is 0, and the output is driven only while bit 1 is 0. A raise made while bit 1 is 1 is lost.
- R12: Reading status at command offset 7 clears a pending interrupt. Reading alternate status at control offset 0 does not.
- R13: Any other command code pulses the transfer strobe with the code and slot and leaves status, error and the interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_ctl | input | 1 | 1 selects the control block, 0 the command block |
| hst_off | input | 3 | Register offset inside the chosen block |
| hst_wdata | input | 8 | Write data |
| hst_rdata | output | 8 | Read data, combinational on the current state |
| slot0_kind | input | 2 | Slot 0 device kind: 0 none, 1 disk, 2 packet, 3 none |
| slot1_kind | input | 2 | Slot 1 device kind, same coding |
| irq | output | 1 | Channel interrupt request |
| xfer_start | output | 1 | One-cycle strobe to the transfer engine |
| xfer_cmd | output | 8 | Command code carried with the strobe |
| xfer_slot | output | 1 | Slot carried with the strobe |

## Verification
The bench builds the block with its default parameters: reset bit 2, interrupt-disable bit 1, slot-select bit 4 and a packet signature of 0xEB14. With these values every encoding stated in the requirements can be seen directly on the ports. Slot kinds are changed between accesses, so one run covers identify and packet commands on both matching and wrong device types, selection of an empty slot, and the signature load on the falling edge of the reset bit. Interrupt masking is exercised in each order: a raise while masked, masking after a raise, and unmasking again.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_DISK = 2'd1,
    KIND_PKT  = 2'd2,
    KIND_RSVD = 2'd3
  } dev_kind_e;

  typedef enum logic [2:0] {
    OUT_FORWARD = 3'd0,
    OUT_ABORT   = 3'd1,
    OUT_IDENT   = 3'd2,
    OUT_PKTCMD  = 3'd3,
    OUT_NODATA  = 3'd4
  } cmd_out_e;

  typedef struct packed {
    logic [7:0] cnt;
    logic [7:0] num;
    logic [7:0] cyl_lo;
    logic [7:0] cyl_hi;
  } slot_regs_t;

  // command block offsets
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_ERR  = 3'd1;
  localparam logic [2:0] OFF_CNT  = 3'd2;
  localparam logic [2:0] OFF_NUM  = 3'd3;
  localparam logic [2:0] OFF_CYLL = 3'd4;
  localparam logic [2:0] OFF_CYLH = 3'd5;
  localparam logic [2:0] OFF_DH   = 3'd6;
  localparam logic [2:0] OFF_CMD  = 3'd7;

  // status bits
  localparam int ST_BSY = 7;
  localparam int ST_RDY = 6;
  localparam int ST_WF  = 5;
  localparam int ST_DSC = 4;
  localparam int ST_DRQ = 3;
  localparam int ST_ERR = 0;
  localparam int ER_ABRT = 2;

  // command codes
  localparam logic [7:0] CMD_ID_DISK = 8'hEC;
  localparam logic [7:0] CMD_ID_PKT  = 8'hA1;
  localparam logic [7:0] CMD_PACKET  = 8'hA0;
  localparam logic [7:0] CMD_SETFEAT = 8'hEF;
  localparam logic [7:0] CMD_INITP   = 8'h91;
  localparam logic [7:0] CMD_RECAL   = 8'h10;

  localparam logic [7:0] ST_ABORT = 8'h41;
  localparam logic [7:0] ER_ABORT = 8'h04;
  localparam logic [7:0] ST_IDENT = 8'h58;
  localparam logic [7:0] ST_SRST  = 8'h90;
  localparam logic [7:0] ER_DIAG  = 8'h01;
  localparam logic [7:0] DH_FORCE = 8'hA0;

  function automatic logic kind_present(input logic [1:0] k);
    return (k == KIND_DISK) || (k == KIND_PKT);
  endfunction

  function automatic cmd_out_e classify(input logic [7:0] code, input logic [1:0] k);
    cmd_out_e o;
    case (code)
      CMD_ID_DISK: o = (k == KIND_DISK) ? OUT_IDENT : OUT_ABORT;
      CMD_ID_PKT:  o = (k == KIND_PKT) ? OUT_IDENT : OUT_ABORT;
      CMD_PACKET:  o = (k == KIND_PKT) ? OUT_PKTCMD : OUT_ABORT;
      CMD_SETFEAT, CMD_INITP, CMD_RECAL: o = OUT_NODATA;
      default:     o = OUT_FORWARD;
    endcase
    return o;
  endfunction

  function automatic logic [7:0] status_after(input cmd_out_e o, input logic [7:0] st);
    logic [7:0] r;
    r = st;
    case (o)
      OUT_ABORT:  r = ST_ABORT;
      OUT_IDENT:  r = ST_IDENT;
      OUT_PKTCMD: begin
        r[ST_BSY] = 1'b0;
        r[ST_WF]  = 1'b0;
        r[ST_ERR] = 1'b0;
        r[ST_DRQ] = 1'b1;
      end
      OUT_NODATA: begin
        r[ST_BSY] = 1'b0;
        r[ST_ERR] = 1'b0;
        r[ST_RDY] = 1'b1;
        r[ST_DSC] = 1'b1;
      end
      default: r = st;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] error_after(input cmd_out_e o, input logic [7:0] er);
    logic [7:0] r;
    case (o)
      OUT_ABORT: r = ER_ABORT;
      OUT_IDENT: r = 8'h00;
      default:   r = er;
    endcase
    return r;
  endfunction

  function automatic logic raises_irq(input cmd_out_e o);
    return (o == OUT_ABORT) || (o == OUT_IDENT) || (o == OUT_NODATA);
  endfunction

  function automatic logic goes_to_engine(input cmd_out_e o);
    return (o == OUT_IDENT) || (o == OUT_PKTCMD) || (o == OUT_FORWARD);
  endfunction

endpackage

// File: rtl/ata_tf_slot.sv
module ata_tf_slot
  import ata_tf_pkg::*;
#(
  parameter logic [15:0] PACKET_SIG = 16'hEB14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cnt,
  input  logic       wr_num,
  input  logic       wr_cyl_lo,
  input  logic       wr_cyl_hi,
  input  logic [7:0] wdata,
  input  logic       cnt_to_one,
  input  logic       restore,
  input  logic [1:0] kind,
  output slot_regs_t regs
);

  localparam logic [7:0] ONE = 8'h01;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs.cnt    <= ONE;
      regs.num    <= ONE;
      regs.cyl_lo <= 8'h00;
      regs.cyl_hi <= 8'h00;
    end else if (restore) begin
      regs.cnt <= ONE;
      regs.num <= ONE;
      if (kind == KIND_PKT) begin
        regs.cyl_lo <= PACKET_SIG[7:0];
        regs.cyl_hi <= PACKET_SIG[15:8];
      end else begin
        regs.cyl_lo <= 8'h00;
        regs.cyl_hi <= 8'h00;
      end
    end else begin
      if (wr_cnt)     regs.cnt    <= wdata;
      if (cnt_to_one) regs.cnt    <= ONE;
      if (wr_num)     regs.num    <= wdata;
      if (wr_cyl_lo)  regs.cyl_lo <= wdata;
      if (wr_cyl_hi)  regs.cyl_hi <= wdata;
    end
  end

endmodule

// File: rtl/ata_tf_cmd_decode.sv
module ata_tf_cmd_decode
  import ata_tf_pkg::*;
(
  input  logic [7:0] code,
  input  logic [1:0] kind,
  input  logic [7:0] cur_st,
  input  logic [7:0] cur_er,
  output cmd_out_e   outcome,
  output logic [7:0] nxt_st,
  output logic [7:0] nxt_er,
  output logic       want_irq,
  output logic       want_xfer
);

  always_comb begin
    outcome   = classify(code, kind);
    nxt_st    = status_after(outcome, cur_st);
    nxt_er    = error_after(outcome, cur_er);
    want_irq  = raises_irq(outcome);
    want_xfer = goes_to_engine(outcome);
  end

endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic ack,
  input  logic flush,
  input  logic masked,
  output logic irq
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (flush) begin
      pend_q <= 1'b0;
    end else if (raise && !masked) begin
      pend_q <= 1'b1;
    end else if (ack) begin
      pend_q <= 1'b0;
    end
  end

  assign irq = pend_q && !masked;

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int          SRST_BIT   = 2,
  parameter int          NIEN_BIT   = 1,
  parameter int          SEL_BIT    = 4,
  parameter logic [7:0]  CTRL_RESET = 8'h08,
  parameter logic [15:0] PACKET_SIG = 16'hEB14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hst_wr,
  input  logic       hst_rd,
  input  logic       hst_ctl,
  input  logic [2:0] hst_off,
  input  logic [7:0] hst_wdata,
  output logic [7:0] hst_rdata,
  input  logic [1:0] slot0_kind,
  input  logic [1:0] slot1_kind,
  output logic       irq,
  output logic       xfer_start,
  output logic [7:0] xfer_cmd,
  output logic       xfer_slot
);

  localparam int         NSLOT     = 2;
  localparam logic [7:0] NIEN_MASK = 8'(1) << NIEN_BIT;
  localparam logic [7:0] HEAD_MASK = 8'h0F;

  logic [1:0] kind_in [NSLOT];
  assign kind_in[0] = slot0_kind;
  assign kind_in[1] = slot1_kind;

  logic [7:0] ctl_q, dh_q, st_q, er_q;
  slot_regs_t slot_q [NSLOT];

  // access events
  logic cb_wr, cb_rd, cmd_wr, dh_wr, ctl_wr, srst_rise, srst_fall, status_rd;
  logic sel, new_sel, sel_present;
  logic [1:0] sel_kind;

  assign cb_wr     = hst_wr && !hst_ctl;
  assign cb_rd     = hst_rd && !hst_ctl;
  assign cmd_wr    = cb_wr && (hst_off == OFF_CMD);
  assign dh_wr     = cb_wr && (hst_off == OFF_DH);
  assign ctl_wr    = hst_wr && hst_ctl && !hst_off[0];
  assign srst_rise = ctl_wr && !ctl_q[SRST_BIT] && hst_wdata[SRST_BIT];
  assign srst_fall = ctl_wr && ctl_q[SRST_BIT] && !hst_wdata[SRST_BIT];
  assign status_rd = cb_rd && (hst_off == OFF_CMD);

  assign sel         = dh_q[SEL_BIT];
  assign new_sel     = hst_wdata[SEL_BIT];
  assign sel_kind    = kind_in[sel];
  assign sel_present = kind_present(sel_kind);

  // command decode
  cmd_out_e   dec_out;
  logic [7:0] dec_st, dec_er;
  logic       dec_irq, dec_xfer, irq_raise;

  ata_tf_cmd_decode u_dec (
    .code      (hst_wdata),
    .kind      (sel_kind),
    .cur_st    (st_q),
    .cur_er    (er_q),
    .outcome   (dec_out),
    .nxt_st    (dec_st),
    .nxt_er    (dec_er),
    .want_irq  (dec_irq),
    .want_xfer (dec_xfer)
  );

  assign irq_raise = cmd_wr && dec_irq;

  // per-slot address registers
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    ata_tf_slot #(.PACKET_SIG(PACKET_SIG)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cnt     (cb_wr && (hst_off == OFF_CNT)),
      .wr_num     (cb_wr && (hst_off == OFF_NUM)),
      .wr_cyl_lo  (cb_wr && (hst_off == OFF_CYLL)),
      .wr_cyl_hi  (cb_wr && (hst_off == OFF_CYLH)),
      .wdata      (hst_wdata),
      .cnt_to_one (cmd_wr && (dec_out == OUT_PKTCMD) && (sel == 1'(g))),
      .restore    (srst_fall),
      .kind       (kind_in[g]),
      .regs       (slot_q[g])
    );
  end

  // shared channel registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTRL_RESET;
      dh_q  <= 8'h00;
      st_q  <= 8'h00;
      er_q  <= ER_DIAG;
    end else begin
      if (ctl_wr) begin
        ctl_q <= srst_rise ? (hst_wdata & ~NIEN_MASK) : hst_wdata;
      end
      if (srst_rise) begin
        st_q <= ST_SRST;
        er_q <= ER_DIAG;
      end else if (srst_fall) begin
        st_q[ST_BSY] <= 1'b0;
        st_q[ST_RDY] <= 1'b1;
        dh_q         <= dh_q & ~HEAD_MASK;
      end
      if (dh_wr) begin
        dh_q <= hst_wdata | DH_FORCE;
        if (!kind_present(kind_in[new_sel])) begin
          er_q[ER_ABRT] <= 1'b1;
          st_q[ST_ERR]  <= 1'b1;
        end
      end
      if (cmd_wr) begin
        st_q <= dec_st;
        er_q <= dec_er;
      end
    end
  end

  // engine strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_start <= 1'b0;
      xfer_cmd   <= 8'h00;
      xfer_slot  <= 1'b0;
    end else begin
      xfer_start <= cmd_wr && dec_xfer;
      if (cmd_wr && dec_xfer) begin
        xfer_cmd  <= hst_wdata;
        xfer_slot <= sel;
      end
    end
  end

  ata_tf_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .raise  (irq_raise),
    .ack    (status_rd),
    .flush  (srst_rise),
    .masked (ctl_q[NIEN_BIT]),
    .irq    (irq)
  );

  // read mux
  always_comb begin
    hst_rdata = 8'h00;
    if (hst_ctl) begin
      if (hst_off[0])       hst_rdata = 8'hFF;
      else if (sel_present) hst_rdata = st_q;
    end else if (!sel_present) begin
      if (hst_off == OFF_DH) hst_rdata = DH_FORCE;
    end else begin
      case (hst_off)
        OFF_ERR:  hst_rdata = er_q;
        OFF_CNT:  hst_rdata = slot_q[sel].cnt;
        OFF_NUM:  hst_rdata = slot_q[sel].num;
        OFF_CYLL: hst_rdata = slot_q[sel].cyl_lo;
        OFF_CYLH: hst_rdata = slot_q[sel].cyl_hi;
        OFF_DH:   hst_rdata = dh_q;
        OFF_CMD:  hst_rdata = st_q;
        default:  hst_rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk
  import ata_tf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       hst_rd,
  input logic       hst_wr,
  input logic       hst_ctl,
  input logic [2:0] hst_off,
  input logic [7:0] hst_rdata,
  input logic       irq,
  input logic       cmd_wr,
  input cmd_out_e   dec_out,
  input logic       irq_raise,
  input logic       srst_rise,
  input logic       dh_wr,
  input logic       ctl_wr,
  input logic [7:0] st_q,
  input logic [7:0] er_q,
  input logic [7:0] dh_q
);

  a_r3_dh_forced: assert property (@(posedge clk) disable iff (!rst_n)
    dh_wr |=> (dh_q[7] && dh_q[5]));

  a_r4_addr_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && hst_ctl && hst_off[0]) |-> (hst_rdata == 8'hFF));

  a_r5_srst_rise: assert property (@(posedge clk) disable iff (!rst_n)
    srst_rise |=> (st_q == 8'h90 && er_q == 8'h01 && !irq));

  a_r7_abort_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && dec_out == OUT_ABORT) |=> (st_q == 8'h41 && er_q == 8'h04));

  a_r10_packet_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && dec_out == OUT_PKTCMD) |=> (irq == $past(irq)));

  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(irq_raise) || $past(ctl_wr)));

  a_r12_status_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !hst_wr && !hst_ctl && hst_off == 3'd7) |=> !irq);

endmodule

bind ata_taskfile ata_taskfile_chk u_chk (.*);

// File: tb/sim_ata_taskfile.sv
module sim_ata_taskfile;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_wr = 1'b0, hst_rd = 1'b0, hst_ctl = 1'b0;
  logic [2:0] hst_off = 3'd0;
  logic [7:0] hst_wdata = 8'h00;
  logic [7:0] hst_rdata;
  logic [1:0] kind0 = 2'd1, kind1 = 2'd2;
  logic       irq, xfer_start, xfer_slot;
  logic [7:0] xfer_cmd;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int m_ctl, m_dh, m_st, m_er, m_pend, m_xs, m_xc, m_xsl;
  int m_sc[2], m_sn[2], m_cl[2], m_ch[2];

  always #(CLK_P/2) clk = ~clk;

  ata_taskfile u0 (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_ctl(hst_ctl),
    .hst_off(hst_off), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .slot0_kind(kind0), .slot1_kind(kind1), .irq(irq),
    .xfer_start(xfer_start), .xfer_cmd(xfer_cmd), .xfer_slot(xfer_slot)
  );

  function automatic int kind_of(int s);
    return (s == 0) ? int'(kind0) : int'(kind1);
  endfunction

  function automatic bit here(int s);
    return kind_of(s) == 1 || kind_of(s) == 2;
  endfunction

  function automatic int model_read(bit ctl, int off);
    int s;
    s = (m_dh >> 4) & 1;
    if (ctl) return (off % 2 == 1) ? 8'hFF : (here(s) ? m_st : 0);
    if (!here(s)) return (off == 6) ? 8'hA0 : 0;
    case (off)
      1: return m_er;
      2: return m_sc[s];
      3: return m_sn[s];
      4: return m_cl[s];
      5: return m_ch[s];
      6: return m_dh;
      7: return m_st;
      default: return 0;
    endcase
  endfunction

  task automatic raise();
    if (((m_ctl >> 1) & 1) == 0) m_pend = 1;
  endtask

  task automatic model_cmd(int code);
    int s, k;
    s = (m_dh >> 4) & 1;
    k = kind_of(s);
    if ((code == 8'hEC && k == 1) || (code == 8'hA1 && k == 2)) begin
      m_st = 8'h58; m_er = 0; raise();
      m_xs = 1; m_xc = code; m_xsl = s;
    end else if (code == 8'hEC || code == 8'hA1 || (code == 8'hA0 && k != 2)) begin
      m_st = 8'h41; m_er = 8'h04; raise();
    end else if (code == 8'hA0) begin
      m_sc[s] = 1;
      m_st = (m_st & ~8'hA1) | 8'h08;
      m_xs = 1; m_xc = code; m_xsl = s;
    end else if (code == 8'hEF || code == 8'h91 || code == 8'h10) begin
      m_st = (m_st & ~8'h81) | 8'h50; raise();
    end else begin
      m_xs = 1; m_xc = code; m_xsl = s;
    end
  endtask

  task automatic model_apply(bit wr, bit rd, bit ctl, int off, int wd);
    m_xs = 0;
    if (rd && !ctl && off == 7) m_pend = 0;
    if (wr && ctl && (off % 2 == 0)) begin
      if (((m_ctl >> 2) & 1) == 0 && ((wd >> 2) & 1) == 1) begin
        m_st = 8'h90; m_er = 8'h01; m_pend = 0;
        m_ctl = wd & ~2;
      end else begin
        if (((m_ctl >> 2) & 1) == 1 && ((wd >> 2) & 1) == 0) begin
          m_st = (m_st & ~8'h80) | 8'h40;
          m_dh = m_dh & 8'hF0;
          for (int i = 0; i < 2; i++) begin
            m_sc[i] = 1; m_sn[i] = 1;
            m_cl[i] = (kind_of(i) == 2) ? 8'h14 : 0;
            m_ch[i] = (kind_of(i) == 2) ? 8'hEB : 0;
          end
        end
        m_ctl = wd;
      end
    end
    if (wr && !ctl) begin
      case (off)
        2: begin m_sc[0] = wd; m_sc[1] = wd; end
        3: begin m_sn[0] = wd; m_sn[1] = wd; end
        4: begin m_cl[0] = wd; m_cl[1] = wd; end
        5: begin m_ch[0] = wd; m_ch[1] = wd; end
        6: begin
          m_dh = wd | 8'hA0;
          if (!here((wd >> 4) & 1)) begin m_er = m_er | 4; m_st = m_st | 1; end
        end
        7: model_cmd(wd);
        default: ;
      endcase
    end
  endtask

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // one bus cycle; called at a falling edge, returns at the next falling edge
  task automatic cyc(string tag, bit wr, bit rd, bit ctl, int off, int wd);
    hst_wr = wr; hst_rd = rd; hst_ctl = ctl;
    hst_off = 3'(off); hst_wdata = 8'(wd);
    #1;
    if (rd) check(tag, "rdata", int'(hst_rdata), model_read(ctl, off));
    @(posedge clk); #1;
    model_apply(wr, rd, ctl, off, wd);
    @(negedge clk);
    hst_wr = 1'b0; hst_rd = 1'b0;
    check(tag, "irq", int'(irq), (m_pend && ((m_ctl >> 1) & 1) == 0) ? 1 : 0);
    check(tag, "xfer_start", int'(xfer_start), m_xs);
    if (m_xs) begin
      check(tag, "xfer_cmd", int'(xfer_cmd), m_xc);
      check(tag, "xfer_slot", int'(xfer_slot), m_xsl);
    end
  endtask

  task automatic wrc(string tag, int off, int wd); cyc(tag, 1, 0, 0, off, wd); endtask
  task automatic rdc(string tag, int off);         cyc(tag, 0, 1, 0, off, 0);  endtask
  task automatic wctl(string tag, int wd);         cyc(tag, 1, 0, 1, 0, wd);   endtask
  task automatic ralt(string tag);                 cyc(tag, 0, 1, 1, 0, 0);    endtask

  task automatic read_all(string tag);
    for (int o = 0; o < 8; o++) rdc(tag, o);
    ralt(tag);
    cyc(tag, 0, 1, 1, 1, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_ctl = 8'h08; m_dh = 0; m_st = 0; m_er = 1; m_pend = 0;
    m_xs = 0; m_xc = 0; m_xsl = 0;
    for (int i = 0; i < 2; i++) begin m_sc[i] = 1; m_sn[i] = 1; m_cl[i] = 0; m_ch[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    read_all("R1");

    // R2 shared writes, per-slot readback
    wrc("R2", 2, 8'h22); wrc("R2", 3, 8'h33); wrc("R2", 4, 8'h44); wrc("R2", 5, 8'h55);
    read_all("R2");
    wrc("R3", 6, 8'h10);
    read_all("R2");

    // R7/R8: disk identify to packet slot aborts, alternate read keeps irq
    wrc("R7", 7, 8'hEC);
    ralt("R12"); rdc("R1", 1); rdc("R12", 7); rdc("R12", 7);
    wrc("R8", 7, 8'hA1); rdc("R8", 1); rdc("R12", 7);

    // R10 packet command on packet slot, then on disk slot
    wrc("R10", 7, 8'hA0);
    rdc("R10", 2); rdc("R10", 7);
    wrc("R10", 6, 8'h00); rdc("R10", 2);
    wrc("R10", 7, 8'hA0); rdc("R12", 7);
    wrc("R8", 7, 8'hEC); rdc("R12", 7);
    wrc("R8", 7, 8'hA1); rdc("R12", 7);

    // R9 no-data commands
    wrc("R7", 7, 8'hEC); wrc("R9", 7, 8'hEF); rdc("R9", 1); rdc("R12", 7);
    wrc("R9", 7, 8'h91); rdc("R12", 7);
    wrc("R9", 7, 8'h10); rdc("R12", 7);

    // R13 forwarded code
    wrc("R13", 7, 8'h20); rdc("R13", 7); rdc("R13", 1);
    wrc("R13", 6, 8'h10); wrc("R13", 7, 8'hC8);

    // R11 masking
    wctl("R11", 8'h02); wrc("R11", 7, 8'hEF); wctl("R11", 8'h00);
    wrc("R11", 7, 8'hEF); wctl("R11", 8'h02); wctl("R11", 8'h00);
    rdc("R12", 7);

    // R3/R4 empty slot
    kind1 = 2'd0;
    wrc("R3", 6, 8'h1F);
    read_all("R4");
    kind1 = 2'd3;
    read_all("R4");
    wrc("R3", 6, 8'h05); rdc("R3", 1); rdc("R3", 7); rdc("R3", 6);
    kind1 = 2'd2;

    // R5/R6 soft reset edges
    wrc("R5", 7, 8'hEF);
    wctl("R5", 8'h06);
    read_all("R5");
    wctl("R5", 8'h06);
    wctl("R6", 8'h02);
    read_all("R6");
    wrc("R6", 6, 8'h10);
    read_all("R6");
    wctl("R5", 8'h04); wctl("R6", 8'h00);
    wrc("R5", 7, 8'h91);
    rdc("R12", 7);
    repeat (2) cyc("R1", 0, 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule